// File: doc/BRIEF.md
# Binary-Search Assisted Phase Controller for Clock Recovery

This block is the digital phase-control core of an interpolator-based clock recovery loop. It takes early/late decisions from a bang-bang phase detector and produces an N-bit phase code for a phase interpolator. After reset, or when a new burst is announced, it finds the phase quickly. It runs a successive-approximation binary search that resolves one code bit per step strobe, beginning with the most significant bit. A majority vote of detector decisions, taken after a settle delay, decides each bit.

The search writes straight into the upper bits of the loop filter's phase accumulator. No separate search register exists. When the least significant bit is resolved, the resolved code becomes the filter's starting state. The block then switches to proportional-integral tracking, which is driven by every valid decision. The step strobe comes from outside, so search steps can run at a rate unrelated to tracking updates.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: After reset, and in the cycle after `burst_i` is sampled high, `code_o` equals 2^(N-1) (only the top bit set, 32 for N=6), `lock_o` is 0 and `mode_o` is 0 (search).
- R2: In search, a step strobe resolves the current trial bit. The bit is kept when the collected vote is positive, where each late decision counts +1 and each early decision counts -1. Otherwise the bit is cleared. The next lower bit is then set as the new trial bit, so a full search leaves `code_o` equal to the per-step majorities, MSB first, with late written as 1.
- R3: Decisions in the first SETTLE clock cycles after a trial bit is set do not count toward the vote.
- R4: A tied vote clears the trial bit. A decision with `valid_i` low, or with `early_i` and `late_i` both high, counts for nothing.
- R5: The search ends after exactly N step strobes. `lock_o` and `mode_o` become 1 in the cycle after the clock edge that samples the Nth strobe, and not before.
- R6: In tracking, each valid decision that is early only or late only first updates the integral term, I += KI for late and I -= KI for early. The accumulator then changes by (+KP for late, -KP for early) + I. `code_o` is the top N bits of the accumulator, which has N+FRAC_W bits.
- R7: The integral term saturates at ±(2^(INT_W-1)-1).
- R8: The accumulator wraps modulo 2^(N+FRAC_W), so the phase code wraps from its maximum to 0 and from 0 to its maximum.
- R9: A burst start during a search restarts the search from the MSB. Any burst start also clears the integral term.
- R10: In tracking, step strobes, invalid decisions and decisions with both flags set leave `code_o` unchanged.
- R11: Once set, `lock_o` stays 1 until the next burst start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_i | input | 1 | Burst start pulse; restarts the search |
| step_i | input | 1 | Search step strobe |
| early_i | input | 1 | Detector says early (lower the code) |
| late_i | input | 1 | Detector says late (raise the code) |
| valid_i | input | 1 | Qualifies early_i / late_i |
| code_o | output | N | Phase code to the interpolator |
| lock_o | output | 1 | Search finished, phase acquired |
| mode_o | output | 1 | 0 = search, 1 = tracking |

## Verification
The search is driven with a table of bit patterns: all zeros, all ones, two alternating patterns and two edge-heavy mixes. These show whether each bit is resolved into the right position and in the right order. Directed searches that mix early votes inside the settle window, tied votes, votes with both flags set and invalid votes show whether the settle delay and the vote-qualification rules work. In tracking, long runs of late and early decisions are compared against a separately written accumulator model. Those runs expose errors in the gain, the integral saturation and the wrap in both directions. A burst in the middle of a search, followed by a short tracking run, shows whether the stale integral term was cleared.

// File: rtl/cdr_pc_pkg.sv
package cdr_pc_pkg;

  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_TRACK  = 1'b1
  } pc_mode_e;

  typedef struct packed {
    logic up;   // one qualified late decision
    logic dn;   // one qualified early decision
  } pd_dec_t;

  // A decision counts only when valid and unambiguous.
  function automatic pd_dec_t pd_decode(input logic valid, input logic early,
                                        input logic late);
    pd_dec_t d;
    d.up = valid & late & ~early;
    d.dn = valid & early & ~late;
    return d;
  endfunction

endpackage

// File: rtl/cdr_sar_seq.sv
module cdr_sar_seq
  import cdr_pc_pkg::*;
#(
  parameter int N      = 6,
  parameter int SETTLE = 2,
  parameter int VOTE_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart_i,
  input  logic                 step_i,
  input  pd_dec_t              dec_i,
  input  logic [N-1:0]         cur_top_i,
  output logic                 active_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 wr_en_o,
  output logic [N-1:0]         wr_top_o,
  output logic                 done_o
);

  localparam int IDX_W = $clog2(N);
  localparam int SC_W  = $clog2(SETTLE + 2);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(N - 1);
  localparam logic [SC_W-1:0]  SC_LOAD = SC_W'(SETTLE);
  localparam logic [N-1:0]     TRIAL0  = {1'b1, {(N-1){1'b0}}};
  localparam logic signed [VOTE_W-1:0] V_ONE  = 1;
  localparam logic signed [VOTE_W-1:0] V_ZERO = 0;
  localparam logic signed [VOTE_W-1:0] V_MAX  = (2 ** (VOTE_W - 1)) - 1;
  localparam logic signed [VOTE_W-1:0] V_MIN  = -((2 ** (VOTE_W - 1)) - 1);

  logic                     active_q;
  logic [IDX_W-1:0]         idx_q;
  logic [SC_W-1:0]          settle_q;
  logic signed [VOTE_W-1:0] vote_q;

  // Resolve trial bit i and plant the next trial bit below it.
  function automatic logic [N-1:0] next_top(input logic [N-1:0] cur,
                                            input logic [IDX_W-1:0] i,
                                            input logic keep);
    logic [N-1:0] t;
    t    = cur;
    t[i] = keep;
    if (i != '0) t[i - 1'b1] = 1'b1;
    return t;
  endfunction

  logic step_ev;    // a search step is taken at this edge
  logic keep_bit;   // majority says late
  logic vote_open;  // settle window has elapsed

  assign step_ev   = active_q & step_i & ~restart_i;
  assign keep_bit  = (vote_q > V_ZERO);
  assign vote_open = (settle_q == '0);

  assign wr_en_o  = restart_i | step_ev;
  assign wr_top_o = restart_i ? TRIAL0 : next_top(cur_top_i, idx_q, keep_bit);
  assign done_o   = step_ev & (idx_q == '0);
  assign active_o = active_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      idx_q    <= IDX_TOP;
      settle_q <= SC_LOAD;
      vote_q   <= V_ZERO;
    end else if (restart_i) begin
      active_q <= 1'b1;
      idx_q    <= IDX_TOP;
      settle_q <= SC_LOAD;
      vote_q   <= V_ZERO;
    end else if (step_ev) begin
      settle_q <= SC_LOAD;
      vote_q   <= V_ZERO;
      if (idx_q == '0) active_q <= 1'b0;
      else             idx_q    <= idx_q - 1'b1;
    end else if (active_q) begin
      if (!vote_open) begin
        settle_q <= settle_q - 1'b1;
      end else if (dec_i.up && vote_q != V_MAX) begin
        vote_q <= vote_q + V_ONE;
      end else if (dec_i.dn && vote_q != V_MIN) begin
        vote_q <= vote_q - V_ONE;
      end
    end
  end

  // R3
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !vote_open && !restart_i && !step_i) |=> (vote_q == $past(vote_q)));

  // R4
  vote_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !dec_i.up && !dec_i.dn && !restart_i && !step_i) |=> $stable(vote_q));

endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_pc_pkg::*;
#(
  parameter int N      = 6,
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8,
  parameter int KP     = 4,
  parameter int KI     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    track_en_i,
  input  pd_dec_t                 dec_i,
  input  logic                    ld_en_i,
  input  logic [N-1:0]            ld_top_i,
  input  logic                    clr_int_i,
  output logic [N-1:0]            code_o,
  output logic signed [INT_W-1:0] integ_o
);

  localparam int ACC_W = N + FRAC_W;
  localparam int I_MAX = (2 ** (INT_W - 1)) - 1;
  localparam logic [ACC_W-1:0] ACC_RST = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]         acc_q;
  logic signed [INT_W-1:0]  integ_q;

  // Integral term after one decision, clamped symmetrically.
  function automatic logic signed [INT_W-1:0] integ_step(
      input logic signed [INT_W-1:0] cur, input logic up);
    int t;
    t = int'(cur) + (up ? KI : -KI);
    if (t >  I_MAX) t =  I_MAX;
    if (t < -I_MAX) t = -I_MAX;
    return INT_W'(t);
  endfunction

  // Accumulator after one decision; wraps modulo 2^ACC_W.
  function automatic logic [ACC_W-1:0] acc_step(
      input logic [ACC_W-1:0] cur, input logic signed [INT_W-1:0] integ_n,
      input logic up);
    int d;
    d = (up ? KP : -KP) + int'(integ_n);
    return cur + ACC_W'(d);
  endfunction

  logic                    trk_ev;
  logic signed [INT_W-1:0] integ_nx;

  assign trk_ev   = track_en_i & (dec_i.up | dec_i.dn);
  assign integ_nx = integ_step(integ_q, dec_i.up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= ACC_RST;
      integ_q <= '0;
    end else begin
      if (ld_en_i) acc_q <= {ld_top_i, {FRAC_W{1'b0}}};
      else if (trk_ev) acc_q <= acc_step(acc_q, integ_nx, dec_i.up);
      if (clr_int_i) integ_q <= '0;
      else if (trk_ev) integ_q <= integ_nx;
    end
  end

  assign code_o  = acc_q[ACC_W-1 -: N];
  assign integ_o = integ_q;

  // R7
  integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(integ_q) <= I_MAX) && (int'(integ_q) >= -I_MAX));

  // R9
  integ_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_int_i |=> (integ_q == '0));

endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_pc_pkg::*;
#(
  parameter int N      = 6,
  parameter int FRAC_W = 8,
  parameter int INT_W  = 8,
  parameter int KP     = 4,
  parameter int KI     = 1,
  parameter int SETTLE = 2,
  parameter int VOTE_W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burst_i,
  input  logic         step_i,
  input  logic         early_i,
  input  logic         late_i,
  input  logic         valid_i,
  output logic [N-1:0] code_o,
  output logic         lock_o,
  output logic         mode_o
);

  localparam int IDX_W = $clog2(N);
  localparam int STC_W = $clog2(N + 2);
  localparam logic [N-1:0] TRIAL0 = {1'b1, {(N-1){1'b0}}};

  pd_dec_t             dec;
  logic                srch_active;
  logic [IDX_W-1:0]    srch_idx;
  logic                srch_wr;
  logic [N-1:0]        srch_top;
  logic                srch_done;
  logic signed [INT_W-1:0] integ;
  logic                lock_q;

  assign dec = pd_decode(valid_i, early_i, late_i);

  cdr_sar_seq #(.N(N), .SETTLE(SETTLE), .VOTE_W(VOTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (burst_i),
    .step_i    (step_i),
    .dec_i     (dec),
    .cur_top_i (code_o),
    .active_o  (srch_active),
    .idx_o     (srch_idx),
    .wr_en_o   (srch_wr),
    .wr_top_o  (srch_top),
    .done_o    (srch_done)
  );

  cdr_loop_filter #(.N(N), .FRAC_W(FRAC_W), .INT_W(INT_W), .KP(KP), .KI(KI)) u_lf (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_en_i (~srch_active & ~burst_i),
    .dec_i      (dec),
    .ld_en_i    (srch_wr),
    .ld_top_i   (srch_top),
    .clr_int_i  (burst_i),
    .code_o     (code_o),
    .integ_o    (integ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= 1'b0;
    else if (burst_i)   lock_q <= 1'b0;
    else if (srch_done) lock_q <= 1'b1;
  end

  assign lock_o = lock_q;
  assign mode_o = srch_active ? MODE_SEARCH : MODE_TRACK;

  // Step strobes consumed by the current search, for the budget check.
  logic [STC_W-1:0] step_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        step_cnt_q <= '0;
    else if (burst_i)                  step_cnt_q <= '0;
    else if (srch_active && step_i)    step_cnt_q <= step_cnt_q + 1'b1;
  end

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << srch_idx) - N'(1);

  // R1
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_i |=> (code_o == TRIAL0 && !lock_o && mode_o == MODE_SEARCH));

  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_active |-> ((code_o & below_mask) == '0 && code_o[srch_idx]));

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(step_i && !burst_i));

  // R5
  step_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(step_cnt_q) <= N);

  // R10
  track_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !burst_i && !valid_i) |=> $stable(code_o));

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !burst_i) |=> lock_o);

endmodule

// File: tb/cdr_phase_ctrl_test.sv
module cdr_phase_ctrl_test;

  localparam int N      = 6;
  localparam int FRAC_W = 8;
  localparam int INT_W  = 8;
  localparam int KP     = 4;
  localparam int KI     = 1;
  localparam int SETTLE = 2;
  localparam int ACC_W  = N + FRAC_W;
  localparam int I_LIM  = 127;
  localparam int NPAT   = 6;
  // stimulus pattern (late=1 per step, MSB first) and expected final code
  localparam logic [2*N-1:0] VEC [NPAT] = '{
    {6'h00, 6'h00}, {6'h3F, 6'h3F}, {6'h2A, 6'h2A},
    {6'h15, 6'h15}, {6'h21, 6'h21}, {6'h1E, 6'h1E}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_i = 1'b0, step_i = 1'b0, early_i = 1'b0, late_i = 1'b0, valid_i = 1'b0;
  logic [N-1:0] code_o;
  logic lock_o, mode_o;

  int checks = 0;
  int errors = 0;
  int m_acc = 0;
  int m_int = 0;

  always #2 clk = ~clk;

  cdr_phase_ctrl #(.N(N), .FRAC_W(FRAC_W), .INT_W(INT_W), .KP(KP), .KI(KI),
                   .SETTLE(SETTLE), .VOTE_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .burst_i(burst_i), .step_i(step_i),
    .early_i(early_i), .late_i(late_i), .valid_i(valid_i),
    .code_o(code_o), .lock_o(lock_o), .mode_o(mode_o));

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic up, input logic dn, input logic v);
    valid_i = v; late_i = up; early_i = dn;
    tick;
    valid_i = 1'b0; late_i = 1'b0; early_i = 1'b0;
  endtask

  task automatic burst;
    burst_i = 1'b1; tick; burst_i = 1'b0;
    m_int = 0;
  endtask

  task automatic strobe;
    step_i = 1'b1; tick; step_i = 1'b0;
  endtask

  task automatic srch_bit(input logic late);
    repeat (SETTLE) tick;
    pulse(late, ~late, 1'b1);
    pulse(late, ~late, 1'b1);
    pulse(~late, late, 1'b1);
    strobe;
  endtask

  task automatic run_search(input logic [N-1:0] pat);
    for (int i = N - 1; i >= 0; i--) srch_bit(pat[i]);
    m_acc = int'(pat) << FRAC_W;
    m_int = 0;
  endtask

  // Independent model of one tracking decision.
  task automatic track(input logic up, input logic dn, input logic v);
    pulse(up, dn, v);
    if (v && (up != dn)) begin
      m_int = m_int + (up ? KI : -KI);
      if (m_int > I_LIM) m_int = I_LIM;
      if (m_int < -I_LIM) m_int = -I_LIM;
      m_acc = (m_acc + (up ? KP : -KP) + m_int) & ((1 << ACC_W) - 1);
    end
  endtask

  function automatic int m_code();
    return m_acc >> FRAC_W;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick;
    // R1 reset state
    chk("R1 reset code", int'(code_o), 32);
    chk("R1 reset lock", int'(lock_o), 0);
    chk("R1 reset mode", int'(mode_o), 0);
    rst_n = 1'b1;
    tick;

    // R2 table of search patterns
    for (int v = 0; v < NPAT; v++) begin
      burst;
      chk("R1 burst code", int'(code_o), 32);
      run_search(VEC[v][2*N-1:N]);
      chk("R2 searched code", int'(code_o), int'(VEC[v][N-1:0]));
      chk("R5 lock after search", int'(lock_o), 1);
      chk("R5 mode after search", int'(mode_o), 1);
    end

    // R5 no lock before the Nth strobe
    burst;
    for (int i = N - 1; i >= 1; i--) srch_bit(1'b1);
    chk("R5 lock before last step", int'(lock_o), 0);
    chk("R5 mode before last step", int'(mode_o), 0);
    srch_bit(1'b0);
    chk("R5 lock after last step", int'(lock_o), 1);
    chk("R2 code 111110", int'(code_o), 62);

    // R3 votes inside the settle window are ignored
    burst;
    pulse(1'b0, 1'b1, 1'b1);
    pulse(1'b0, 1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b1);
    strobe;
    chk("R3 settle window", int'(code_o), 48);

    // R4 tie clears
    burst;
    repeat (SETTLE) tick;
    pulse(1'b1, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b1);
    strobe;
    chk("R4 tie clears", int'(code_o), 16);

    // R4 both flags ignored
    burst;
    repeat (SETTLE) tick;
    pulse(1'b1, 1'b1, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b1);
    strobe;
    chk("R4 both flags ignored", int'(code_o), 48);

    // R4 invalid ignored
    burst;
    repeat (SETTLE) tick;
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b0, 1'b1, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    strobe;
    chk("R4 invalid ignored", int'(code_o), 48);

    // R6 tracking up then down
    burst;
    run_search(6'h20);
    for (int i = 0; i < 20; i++) track(1'b1, 1'b0, 1'b1);
    chk("R6 track late run", int'(code_o), m_code());
    for (int i = 0; i < 30; i++) track(1'b0, 1'b1, 1'b1);
    chk("R6 track early run", int'(code_o), m_code());

    // R10 strobes, invalid and ambiguous decisions in tracking
    strobe; strobe;
    track(1'b1, 1'b0, 1'b0);
    track(1'b1, 1'b1, 1'b1);
    repeat (4) tick;
    chk("R10 tracking hold", int'(code_o), m_code());
    chk("R11 lock held", int'(lock_o), 1);

    // R8 wrap upward
    burst;
    run_search(6'h3F);
    for (int i = 0; i < 40; i++) track(1'b1, 1'b0, 1'b1);
    chk("R8 wrap up", int'(code_o), m_code());
    chk("R8 wrapped low", int'(code_o < 6'd32), 1);

    // R8 wrap downward
    burst;
    run_search(6'h00);
    for (int i = 0; i < 40; i++) track(1'b0, 1'b1, 1'b1);
    chk("R8 wrap down", int'(code_o), m_code());
    chk("R8 wrapped high", int'(code_o > 6'd32), 1);

    // R7 integral saturation
    burst;
    run_search(6'h20);
    for (int i = 0; i < 200; i++) track(1'b1, 1'b0, 1'b1);
    chk("R7 saturated climb", int'(code_o), m_code());
    for (int i = 0; i < 20; i++) track(1'b0, 1'b1, 1'b1);
    chk("R7 after saturation", int'(code_o), m_code());

    // R9 burst in mid-search restarts and clears integral
    for (int i = 0; i < 10; i++) track(1'b1, 1'b0, 1'b1);
    burst;
    srch_bit(1'b0); srch_bit(1'b1); srch_bit(1'b1);
    burst;
    chk("R9 restart code", int'(code_o), 32);
    chk("R9 restart lock", int'(lock_o), 0);
    chk("R9 restart mode", int'(mode_o), 0);
    run_search(6'h10);
    chk("R9 search after restart", int'(code_o), 16);
    track(1'b1, 1'b0, 1'b1);
    track(1'b1, 1'b0, 1'b1);
    chk("R9 integral cleared", int'(code_o), m_code());

    // R1 reset during tracking
    rst_n = 1'b0;
    tick;
    chk("R1 reset code again", int'(code_o), 32);
    chk("R1 reset lock again", int'(lock_o), 0);
    rst_n = 1'b1;
    tick;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule